// File: doc/BRIEF.md
# Dual-Channel DAC Update Sequencer

This block sits between the receive side of a cyclic shared-memory network and a two-channel, 16-bit serial DAC. Once per network cycle it receives a 64-bit output record. The record carries two channel words, a discrete output byte and a sequence number. When the record is committed, the block writes both channel words into the DAC's input registers over SPI. It then sends a check frame and pulses one active-low load strobe, so that both analog outputs move at the same instant.

A strap picks the commit policy. In the first policy, every committed record refreshes the outputs. In the second, the outputs refresh only when the record's sequence number has changed and is nonzero. When the data source is reported lost and the clear strap is set, the block holds the DAC clear line low. When the clear strap is not set, the block holds the last values instead.

The block echoes the applied channel words, the discrete byte and the sequence number back to the sender. It checks each write against the word the DAC returns on MISO, and keeps a per-update fault flag plus a fault flag that stays set until reset. The configuration straps are captured once as reset ends and are reported in a status byte.

Top module: `dac_pair_sequencer`

## Requirements
- R1: Record fields are ch0 = bits 15:0, ch1 = bits 31:16, discrete byte = bits 39:32 and sequence number = bits 63:56. Bits 55:40 have no effect.
- R2: In cycle mode (strap_mode_n high), each commit_slot pulse that follows a newly received record starts one output update.
- R3: In sequence mode (strap_mode_n low), an update starts only if the sequence number differs from the one seen at the previous commit and is not 0x00. A value of 0x00 keeps the outputs unchanged.
- R4: An update sends a ch0 write frame, then a ch1 write frame, then one check frame. Only after that, with chip-select high, does dac_load_n go low for LOAD_LEN cycles. Both channels change on that single strobe.
- R5: Frames are 24 bits, MSB first, with spi_cs_n low for the whole frame and spi_sclk idle low. A write frame is {6'b0, 1'b0, channel bit, 16-bit value}. The check frame is 24'h040000. MOSI changes on the falling SCLK edge, and MISO is sampled on the rising edge.
- R6: echo_ch0 and echo_ch1 read 0x0000 from reset until the first load. After a load they show the applied words.
- R7: While src_lost is high and the clear strap (strap_clr_n) was low at reset, dac_clr_n is low, both echoes read 0x0000 and commits are ignored.
- R8: While src_lost is high and the clear strap was high at reset, dac_clr_n stays high and the echoes and DAC outputs keep their values.
- R9: During the ch1 write frame, MISO must return the ch0 write frame. During the check frame, MISO must return the ch1 write frame. Any mismatch sets spi_err at that update's load. spi_err is refreshed on every update, and spi_err_sticky stays high from the first fault until reset.
- R10: The straps are captured only in the first cycle after reset ends. status = {sticky fault, clear, range, fault, sequence mode, inversion, 0, polarity}, and each strap bit reads 1 when its pin was low.
- R11: Each accepted commit of a new record drives dout with the discrete byte and echo_sn with the sequence number, even when no analog update follows.
- R12: A commit_slot pulse that arrives while an update sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_valid | input | 1 | rec_data holds a new record |
| rec_data | input | 64 | Output record from the network |
| commit_slot | input | 1 | Pulse in the slot following the source station |
| src_lost | input | 1 | Data source currently missing |
| strap_pol_n | input | 1 | Polarity strap, low = bipolar |
| strap_range_n | input | 1 | Range strap, low = wide range |
| strap_mode_n | input | 1 | Update-mode strap, low = sequence mode |
| strap_clr_n | input | 1 | Clear-on-loss strap, low = clear |
| strap_inv_n | input | 1 | Input-inversion strap, low = inverted |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to the DAC |
| spi_cs_n | output | 1 | SPI chip-select, active low |
| spi_miso | input | 1 | SPI data from the DAC |
| dac_load_n | output | 1 | Batch load strobe, active low |
| dac_clr_n | output | 1 | DAC clear line, active low |
| dout | output | 8 | Discrete output byte |
| echo_ch0 | output | 16 | Last applied ch0 word |
| echo_ch1 | output | 16 | Last applied ch1 word |
| echo_sn | output | 8 | Last committed sequence number |
| status | output | 8 | Strap and fault status byte |
| spi_err | output | 1 | Fault flag of the latest update |
| spi_err_sticky | output | 1 | Fault seen since reset |

## Verification
The bench builds the block with SCLK_HALF = 2 and LOAD_LEN = 2. At these values a full three-frame update takes about three hundred clocks, so one run can hold many updates, two strap configurations and a commit dropped mid-sequence. The SPI slave model returns the previous frame on MISO and can flip one bit on request, which exposes the mismatch path. It applies writes only on the load strobe, so an early or per-channel load would be visible.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
    localparam int FRAME_W = 24;
    localparam logic [FRAME_W-1:0] CHECK_FRAME = 24'h040000;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WR0,
        SQ_WR1,
        SQ_CHK,
        SQ_LOAD
    } seq_state_e;

    function automatic logic [FRAME_W-1:0] dac_wr_frame(input logic ch, input logic [15:0] val);
        return {6'd0, 1'b0, ch, val};
    endfunction
endpackage

// File: rtl/spi_frame_xfer.sv
module spi_frame_xfer
    import dac_seq_pkg::*;
#(
    parameter int SCLK_HALF = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n,
    output logic               done,
    output logic [FRAME_W-1:0] rx_word
);
    localparam int DIV_W = $clog2(SCLK_HALF + 1);
    localparam int BIT_W = $clog2(FRAME_W);

    typedef struct packed {
        logic               busy;
        logic               cs_n;
        logic               sclk;
        logic               mosi;
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx;
        logic [BIT_W-1:0]   bitcnt;
        logic [DIV_W-1:0]   div;
        logic               done;
    } xfer_t;

    xfer_t x_d, x_q;

    always_comb begin
        x_d      = x_q;
        x_d.done = 1'b0;
        if (!x_q.busy) begin
            if (start) begin
                x_d.busy   = 1'b1;
                x_d.cs_n   = 1'b0;
                x_d.sclk   = 1'b0;
                x_d.tx     = tx_word;
                x_d.mosi   = tx_word[FRAME_W-1];
                x_d.bitcnt = '0;
                x_d.div    = '0;
            end
        end else if (x_q.div == DIV_W'(SCLK_HALF - 1)) begin
            x_d.div = '0;
            if (!x_q.sclk) begin
                x_d.sclk = 1'b1;
                x_d.rx   = {x_q.rx[FRAME_W-2:0], miso};
            end else begin
                x_d.sclk = 1'b0;
                if (x_q.bitcnt == BIT_W'(FRAME_W - 1)) begin
                    x_d.busy = 1'b0;
                    x_d.cs_n = 1'b1;
                    x_d.mosi = 1'b0;
                    x_d.done = 1'b1;
                end else begin
                    x_d.bitcnt = x_q.bitcnt + 1'b1;
                    x_d.tx     = {x_q.tx[FRAME_W-2:0], 1'b0};
                    x_d.mosi   = x_q.tx[FRAME_W-2];
                end
            end
        end else begin
            x_d.div = x_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q      <= '0;
            x_q.cs_n <= 1'b1;
        end else begin
            x_q <= x_d;
        end
    end

    assign sclk    = x_q.sclk;
    assign mosi    = x_q.mosi;
    assign cs_n    = x_q.cs_n;
    assign done    = x_q.done;
    assign rx_word = x_q.rx;
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
    parameter int N_STRAPS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STRAPS-1:0] pins_n,
    output logic [N_STRAPS-1:0] cfg,
    output logic                taken
);
    typedef struct packed {
        logic [N_STRAPS-1:0] cfg;
        logic                taken;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!c_q.taken) begin
            c_d.cfg   = ~pins_n;
            c_d.taken = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cfg   = c_q.cfg;
    assign taken = c_q.taken;
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
    import dac_seq_pkg::*;
#(
    parameter int LOAD_LEN = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rec_valid,
    input  logic [15:0]        rec_ch0,
    input  logic [15:0]        rec_ch1,
    input  logic [7:0]         rec_do,
    input  logic [7:0]         rec_sn,
    input  logic               commit,
    input  logic               src_lost,
    input  logic               sn_mode,
    input  logic               clr_en,
    input  logic               spi_done,
    input  logic [FRAME_W-1:0] spi_rx,
    output logic               spi_start,
    output logic [FRAME_W-1:0] spi_tx,
    output logic               load_n,
    output logic               clr_n,
    output logic [15:0]        echo0,
    output logic [15:0]        echo1,
    output logic [7:0]         sn_echo,
    output logic [7:0]         dout,
    output logic               err,
    output logic               sticky
);
    localparam int LC_W = $clog2(LOAD_LEN + 1);

    typedef struct packed {
        seq_state_e         state;
        logic [15:0]        r_ch0;
        logic [15:0]        r_ch1;
        logic [7:0]         r_do;
        logic [7:0]         r_sn;
        logic               fresh;
        logic [7:0]         last_sn;
        logic [15:0]        p0;
        logic [15:0]        p1;
        logic               mism;
        logic               load_n;
        logic [LC_W-1:0]    load_cnt;
        logic               clr_n;
        logic [15:0]        echo0;
        logic [15:0]        echo1;
        logic [7:0]         sn_echo;
        logic [7:0]         dout;
        logic               start;
        logic [FRAME_W-1:0] tx;
        logic               err;
        logic               sticky;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  lost_clr;
    logic  go;
    logic  bad;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        lost_clr  = src_lost && clr_en;
        s_d.clr_n = !lost_clr;
        go        = 1'b0;
        bad       = 1'b0;

        unique case (s_q.state)
            SQ_IDLE: begin
                if (commit && s_q.fresh && !src_lost) begin
                    s_d.fresh   = 1'b0;
                    s_d.dout    = s_q.r_do;
                    s_d.sn_echo = s_q.r_sn;
                    s_d.last_sn = s_q.r_sn;
                    go = sn_mode ? ((s_q.r_sn != s_q.last_sn) && (s_q.r_sn != 8'h00)) : 1'b1;
                    if (go) begin
                        s_d.p0    = s_q.r_ch0;
                        s_d.p1    = s_q.r_ch1;
                        s_d.mism  = 1'b0;
                        s_d.tx    = dac_wr_frame(1'b0, s_q.r_ch0);
                        s_d.start = 1'b1;
                        s_d.state = SQ_WR0;
                    end
                end
            end
            SQ_WR0: begin
                if (spi_done) begin
                    s_d.tx    = dac_wr_frame(1'b1, s_q.p1);
                    s_d.start = 1'b1;
                    s_d.state = SQ_WR1;
                end
            end
            SQ_WR1: begin
                if (spi_done) begin
                    s_d.mism  = (spi_rx != dac_wr_frame(1'b0, s_q.p0));
                    s_d.tx    = CHECK_FRAME;
                    s_d.start = 1'b1;
                    s_d.state = SQ_CHK;
                end
            end
            SQ_CHK: begin
                if (spi_done) begin
                    bad          = s_q.mism || (spi_rx != dac_wr_frame(1'b1, s_q.p1));
                    s_d.err      = bad;
                    s_d.sticky   = s_q.sticky || bad;
                    s_d.load_n   = 1'b0;
                    s_d.load_cnt = '0;
                    if (!lost_clr) begin
                        s_d.echo0 = s_q.p0;
                        s_d.echo1 = s_q.p1;
                    end
                    s_d.state = SQ_LOAD;
                end
            end
            SQ_LOAD: begin
                if (s_q.load_cnt == LC_W'(LOAD_LEN - 1)) begin
                    s_d.load_n = 1'b1;
                    s_d.state  = SQ_IDLE;
                end else begin
                    s_d.load_cnt = s_q.load_cnt + 1'b1;
                end
            end
            default: s_d.state = SQ_IDLE;
        endcase

        if (lost_clr) begin
            s_d.echo0 = '0;
            s_d.echo1 = '0;
        end

        if (rec_valid) begin
            s_d.r_ch0 = rec_ch0;
            s_d.r_ch1 = rec_ch1;
            s_d.r_do  = rec_do;
            s_d.r_sn  = rec_sn;
            s_d.fresh = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.state  <= SQ_IDLE;
            s_q.load_n <= 1'b1;
            s_q.clr_n  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign spi_start = s_q.start;
    assign spi_tx    = s_q.tx;
    assign load_n    = s_q.load_n;
    assign clr_n     = s_q.clr_n;
    assign echo0     = s_q.echo0;
    assign echo1     = s_q.echo1;
    assign sn_echo   = s_q.sn_echo;
    assign dout      = s_q.dout;
    assign err       = s_q.err;
    assign sticky    = s_q.sticky;
endmodule

// File: rtl/dac_pair_sequencer.sv
module dac_pair_sequencer
    import dac_seq_pkg::*;
#(
    parameter int SCLK_HALF = 4,
    parameter int LOAD_LEN  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rec_valid,
    input  logic [63:0] rec_data,
    input  logic        commit_slot,
    input  logic        src_lost,
    input  logic        strap_pol_n,
    input  logic        strap_range_n,
    input  logic        strap_mode_n,
    input  logic        strap_clr_n,
    input  logic        strap_inv_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs_n,
    input  logic        spi_miso,
    output logic        dac_load_n,
    output logic        dac_clr_n,
    output logic [7:0]  dout,
    output logic [15:0] echo_ch0,
    output logic [15:0] echo_ch1,
    output logic [7:0]  echo_sn,
    output logic [7:0]  status,
    output logic        spi_err,
    output logic        spi_err_sticky
);
    // strap vector: 0 polarity, 1 range, 2 mode, 3 clear, 4 inversion
    logic [4:0]         cfg;
    logic               cfg_taken;
    logic               x_start;
    logic [FRAME_W-1:0] x_tx;
    logic               x_done;
    logic [FRAME_W-1:0] x_rx;
    logic               unused_ignored;

    assign unused_ignored = ^rec_data[55:40];

    strap_capture #(.N_STRAPS(5)) u_straps (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_n ({strap_inv_n, strap_clr_n, strap_mode_n, strap_range_n, strap_pol_n}),
        .cfg    (cfg),
        .taken  (cfg_taken)
    );

    dac_update_ctrl #(.LOAD_LEN(LOAD_LEN)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_valid (rec_valid),
        .rec_ch0   (rec_data[15:0]),
        .rec_ch1   (rec_data[31:16]),
        .rec_do    (rec_data[39:32]),
        .rec_sn    (rec_data[63:56]),
        .commit    (commit_slot && cfg_taken),
        .src_lost  (src_lost),
        .sn_mode   (cfg[2]),
        .clr_en    (cfg[3]),
        .spi_done  (x_done),
        .spi_rx    (x_rx),
        .spi_start (x_start),
        .spi_tx    (x_tx),
        .load_n    (dac_load_n),
        .clr_n     (dac_clr_n),
        .echo0     (echo_ch0),
        .echo1     (echo_ch1),
        .sn_echo   (echo_sn),
        .dout      (dout),
        .err       (spi_err),
        .sticky    (spi_err_sticky)
    );

    spi_frame_xfer #(.SCLK_HALF(SCLK_HALF)) u_spi (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (x_start),
        .tx_word (x_tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .cs_n    (spi_cs_n),
        .done    (x_done),
        .rx_word (x_rx)
    );

    assign status = {spi_err_sticky, cfg[3], cfg[1], spi_err, cfg[2], cfg[4], 1'b0, cfg[0]};
endmodule

// File: rtl/dac_pair_sequencer_chk.sv
module dac_pair_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        spi_cs_n,
    input logic        spi_sclk,
    input logic        dac_load_n,
    input logic        dac_clr_n,
    input logic [15:0] echo_ch0,
    input logic [15:0] echo_ch1,
    input logic        spi_err,
    input logic        spi_err_sticky,
    input logic        cfg_taken,
    input logic [7:0]  status
);
    a_r4_load_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_load_n |-> spi_cs_n);

    a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    a_r7_clear_zeroes_echo: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_clr_n |-> (echo_ch0 == 16'h0000 && echo_ch1 == 16'h0000));

    a_r9_fault_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        spi_err |-> spi_err_sticky);

    a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        spi_err_sticky |=> spi_err_sticky);

    a_r10_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_taken |=> $stable({status[6:5], status[3:2], status[0]}));
endmodule

bind dac_pair_sequencer dac_pair_sequencer_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .spi_cs_n       (spi_cs_n),
    .spi_sclk       (spi_sclk),
    .dac_load_n     (dac_load_n),
    .dac_clr_n      (dac_clr_n),
    .echo_ch0       (echo_ch0),
    .echo_ch1       (echo_ch1),
    .spi_err        (spi_err),
    .spi_err_sticky (spi_err_sticky),
    .cfg_taken      (cfg_taken),
    .status         (status)
);

// File: tb/dac_pair_sequencer_tb.sv
module dac_pair_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 420;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_valid = 1'b0;
    logic [63:0] rec_data = '0;
    logic        commit_slot = 1'b0;
    logic        src_lost = 1'b0;
    logic        strap_pol_n = 1'b1, strap_range_n = 1'b1, strap_mode_n = 1'b1;
    logic        strap_clr_n = 1'b1, strap_inv_n = 1'b1;
    logic        spi_sclk, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;
    logic        dac_load_n, dac_clr_n;
    logic [7:0]  dout, echo_sn, status;
    logic [15:0] echo_ch0, echo_ch1;
    logic        spi_err, spi_err_sticky;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_pair_sequencer #(.SCLK_HALF(2), .LOAD_LEN(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_data(rec_data),
        .commit_slot(commit_slot), .src_lost(src_lost),
        .strap_pol_n(strap_pol_n), .strap_range_n(strap_range_n),
        .strap_mode_n(strap_mode_n), .strap_clr_n(strap_clr_n), .strap_inv_n(strap_inv_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
        .dac_load_n(dac_load_n), .dac_clr_n(dac_clr_n), .dout(dout),
        .echo_ch0(echo_ch0), .echo_ch1(echo_ch1), .echo_sn(echo_sn), .status(status),
        .spi_err(spi_err), .spi_err_sticky(spi_err_sticky)
    );

    // ---------------- DAC slave model ----------------
    logic [23:0] sh_in = '0, sh_out = '0, prev_frame = '0;
    logic [23:0] fr0 = '0, fr1 = '0, fr2 = '0;
    logic [15:0] in0 = '0, in1 = '0, out0 = '0, out1 = '0;
    bit          corrupt = 0;
    int          n_loads = 0;
    int          frames_since_load = 0;

    always @(negedge spi_cs_n) begin
        sh_in    = '0;
        sh_out   = corrupt ? (prev_frame ^ 24'h000001) : prev_frame;
        spi_miso = sh_out[23];
    end
    always @(posedge spi_sclk) if (!spi_cs_n) sh_in = {sh_in[22:0], spi_mosi};
    always @(negedge spi_sclk) if (!spi_cs_n) begin
        sh_out   = {sh_out[22:0], 1'b0};
        spi_miso = sh_out[23];
    end
    always @(posedge spi_cs_n) if (rst_n) begin
        prev_frame = sh_in;
        fr0 = fr1; fr1 = fr2; fr2 = sh_in;
        frames_since_load++;
        if (sh_in[23:18] == 6'd0 && sh_in[17] == 1'b0) begin
            if (sh_in[16]) in1 = sh_in[15:0];
            else           in0 = sh_in[15:0];
        end
    end
    always @(negedge dac_load_n) begin
        n_chk++;
        if (frames_since_load < 3) begin
            n_err++;
            $display("FAIL R4 load after %0d frames, expected >= 3", frames_since_load);
        end
        out0 = in0; out1 = in1;
        n_loads++;
        frames_since_load = 0;
    end
    always @(negedge dac_clr_n) begin out0 = '0; out1 = '0; end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_rec(input logic [7:0] sn, input logic [15:0] ign,
                                           input logic [7:0] d, input logic [15:0] c1,
                                           input logic [15:0] c0);
        return {sn, ign, d, c1, c0};
    endfunction

    task automatic do_reset(input logic pol_n, input logic rng_n, input logic mode_n,
                            input logic clr_n, input logic inv_n);
        @(negedge clk);
        rst_n = 1'b0;
        strap_pol_n = pol_n; strap_range_n = rng_n; strap_mode_n = mode_n;
        strap_clr_n = clr_n; strap_inv_n = inv_n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] rec);
        @(negedge clk);
        rec_valid = 1'b1; rec_data = rec;
        @(negedge clk);
        rec_valid = 1'b0; commit_slot = 1'b1;
        @(negedge clk);
        commit_slot = 1'b0;
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        do_reset(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R6", "echo_ch0 after reset", {16'h0, echo_ch0}, 32'h0);
        chk("R6", "echo_ch1 after reset", {16'h0, echo_ch1}, 32'h0);
        chk("R4", "load_n idle", {31'h0, dac_load_n}, 32'h1);
        chk("R5", "cs_n idle", {31'h0, spi_cs_n}, 32'h1);
        chk("R9", "spi_err after reset", {31'h0, spi_err}, 32'h0);
        chk("R10", "status after reset", {24'h0, status}, 32'h45);
        strap_mode_n = 1'b0; strap_pol_n = 1'b1; strap_clr_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10", "status ignores strap change", {24'h0, status}, 32'h45);
    endtask

    task automatic t_cycle_mode();
        int l0;
        l0 = n_loads;
        send(mk_rec(8'h00, 16'h0000, 8'h5A, 16'hABCD, 16'h1234));
        settle();
        chk("R2", "one load per commit", n_loads - l0, 32'd1);
        chk("R4", "dac out ch0", {16'h0, out0}, 32'h1234);
        chk("R4", "dac out ch1", {16'h0, out1}, 32'hABCD);
        chk("R5", "ch0 frame", {8'h0, fr0}, 32'h001234);
        chk("R5", "ch1 frame", {8'h0, fr1}, 32'h01ABCD);
        chk("R5", "check frame", {8'h0, fr2}, 32'h040000);
        chk("R6", "echo ch0", {16'h0, echo_ch0}, 32'h1234);
        chk("R6", "echo ch1", {16'h0, echo_ch1}, 32'hABCD);
        chk("R11", "dout", {24'h0, dout}, 32'h5A);
        chk("R9", "no fault on clean link", {31'h0, spi_err}, 32'h0);
        l0 = n_loads;
        send(mk_rec(8'h00, 16'hFFFF, 8'hC3, 16'h8000, 16'h7FFF));
        settle();
        chk("R2", "cycle mode ignores sn 0", n_loads - l0, 32'd1);
        chk("R1", "ch0 field with ignored bits set", {16'h0, out0}, 32'h7FFF);
        chk("R1", "ch1 field with ignored bits set", {16'h0, out1}, 32'h8000);
        chk("R1", "discrete field", {24'h0, dout}, 32'hC3);
    endtask

    task automatic t_busy_commit();
        int l0;
        l0 = n_loads;
        send(mk_rec(8'h11, 16'h0, 8'h01, 16'h2222, 16'h1111));
        repeat (20) @(negedge clk);
        send(mk_rec(8'h12, 16'h0, 8'h02, 16'h4444, 16'h3333));
        settle();
        chk("R12", "commit during sequence dropped", n_loads - l0, 32'd1);
        chk("R12", "ch0 from first record", {16'h0, out0}, 32'h1111);
        chk("R12", "dout from first record", {24'h0, dout}, 32'h01);
    endtask

    task automatic t_fault();
        corrupt = 1;
        send(mk_rec(8'h20, 16'h0, 8'h00, 16'h0AAA, 16'h0555));
        settle();
        corrupt = 0;
        chk("R9", "fault flag on mismatch", {31'h0, spi_err}, 32'h1);
        chk("R9", "sticky on mismatch", {31'h0, spi_err_sticky}, 32'h1);
        chk("R10", "status fault bits", {30'h0, status[7], status[4]}, 32'h3);
        send(mk_rec(8'h21, 16'h0, 8'h00, 16'h0BBB, 16'h0666));
        settle();
        chk("R9", "fault flag refreshed", {31'h0, spi_err}, 32'h0);
        chk("R9", "sticky kept", {31'h0, spi_err_sticky}, 32'h1);
    endtask

    task automatic t_loss_clear();
        int l0;
        @(negedge clk); src_lost = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7", "clear line low", {31'h0, dac_clr_n}, 32'h0);
        chk("R7", "dac outputs cleared", {out1, out0}, 32'h0);
        chk("R7", "echo cleared", {echo_ch1, echo_ch0}, 32'h0);
        l0 = n_loads;
        send(mk_rec(8'h30, 16'h0, 8'h00, 16'h1357, 16'h2468));
        settle();
        chk("R7", "commit ignored while lost", n_loads - l0, 32'd0);
        @(negedge clk); src_lost = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7", "clear line released", {31'h0, dac_clr_n}, 32'h1);
    endtask

    task automatic t_seq_mode();
        int l0;
        do_reset(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R10", "status second strap set", {24'h0, status}, 32'h29);
        chk("R9", "sticky cleared by reset", {31'h0, spi_err_sticky}, 32'h0);
        l0 = n_loads;
        send(mk_rec(8'h00, 16'h0, 8'h77, 16'h1111, 16'h2222));
        settle();
        chk("R3", "sn 0 no update", n_loads - l0, 32'd0);
        chk("R6", "echo still zero before first load", {echo_ch1, echo_ch0}, 32'h0);
        chk("R11", "dout applied without update", {24'h0, dout}, 32'h77);
        send(mk_rec(8'h03, 16'h0, 8'h78, 16'hBEEF, 16'hCAFE));
        settle();
        chk("R3", "new sn updates", n_loads - l0, 32'd1);
        chk("R3", "outputs after sn change", {out1, out0}, 32'hBEEFCAFE);
        chk("R11", "sn echo", {24'h0, echo_sn}, 32'h03);
        send(mk_rec(8'h03, 16'h0, 8'h79, 16'h0001, 16'h0002));
        settle();
        chk("R3", "same sn no update", n_loads - l0, 32'd1);
        chk("R3", "outputs held on same sn", {out1, out0}, 32'hBEEFCAFE);
        send(mk_rec(8'h00, 16'h0, 8'h7A, 16'h0003, 16'h0004));
        settle();
        chk("R3", "sn back to 0 holds", n_loads - l0, 32'd1);
        send(mk_rec(8'h03, 16'h0, 8'h7B, 16'h0005, 16'h0006));
        settle();
        chk("R3", "sn 3 after 0 updates", n_loads - l0, 32'd2);
        chk("R3", "outputs after re-arm", {out1, out0}, 32'h00050006);
    endtask

    task automatic t_loss_hold();
        @(negedge clk); src_lost = 1'b1;
        repeat (10) @(negedge clk);
        chk("R8", "clear line stays high", {31'h0, dac_clr_n}, 32'h1);
        chk("R8", "dac outputs held", {out1, out0}, 32'h00050006);
        chk("R8", "echo held", {echo_ch1, echo_ch0}, 32'h00050006);
        @(negedge clk); src_lost = 1'b0;
    endtask

    initial begin
        t_reset_state();
        t_cycle_mode();
        t_busy_commit();
        t_fault();
        t_loss_clear();
        t_seq_mode();
        t_loss_hold();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule